// File: doc/BRIEF.md
# Always-On Counter and Periodic Timer with RTC-Domain Command Handshake

The block keeps two counters that run on a slow real-time clock. The first is a free-running up-counter that is always on. The second is a periodic timer that counts down from a programmed period and raises an expiry flag each time the period ends. A faster bus clock reaches both through a small register port: one write strobe, an address, write data and combinational read data.

Software sets the period, then sends clear and reset commands. Each command crosses into the RTC domain through a toggle handshake. Its control bits read back as 1 while the command is in flight and fall to 0 on their own once the RTC domain has acted on it. A command written while another is in flight is dropped. A command written before the RTC domain has produced its first edge after power-on is also dropped.

On every RTC edge the RTC domain publishes a snapshot of its state, and the bus domain captures the whole snapshot at once. Every read therefore returns values taken on the same RTC edge. The interrupt output follows the captured expiry flag. The RTC clock must be at least four times slower than the bus clock.

Top module: `aon_ptimer`

## Requirements
- R1: After reset, address 0 (config) reads 1 (bit 0 is the enable). Address 1 (always-on count), address 2 (period), address 3 (command), address 4 (status) and address 5 (timer count) all read 0, and `irq` is 0.
- R2: While config bit 0 is 1, the always-on count at address 1 rises by exactly 1 per RTC edge. Writing 0 to bit 0 freezes the count, and writing 1 makes it advance again.
- R3: Writing address 3 with bit 1 set is the reset command. When the RTC domain carries it out, it loads the timer count (address 5) and the internal period copy from the period register (address 2). The timer does not step on that edge.
- R4: On each RTC edge with a nonzero period, the timer count falls by 1. On the edge where the count is 1, it reloads the period instead and sets the expiry flag, so the flag fires once every period edges.
- R5: With a period of 0, the timer count stays 0 and the expiry flag is never set.
- R6: Status bit 0 (address 4) is the expiry flag. Only a completed clear command (address 3 bit 0) removes it. A reset command alone leaves it set.
- R7: After a command write, the written bits of address 3 read back as 1 until the RTC domain has carried out the command, then read 0 without further writes.
- R8: A command write made while a command is pending is ignored, so the read-back keeps the bits of the first command. Two commands are never carried out on consecutive RTC edges.
- R9: Command writes made before the first RTC edge after reset has reached the bus domain are ignored. They read back 0 and leave the timer count unchanged.
- R10: `irq` equals the captured expiry flag and changes only when a new RTC snapshot is captured in the bus domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-port clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| rtc_clk | input | 1 | Slow real-time clock |
| rtc_rst_n | input | 1 | Active-low reset, RTC domain |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr` |
| irq | output | 1 | Expiry interrupt level |

## Verification
If the down-counter steps wrongly or reloads on the wrong edge, the timer-count read disagrees with the arithmetic model on the very next RTC edge. It also moves the rise of the status bit and of `irq` by at least one period step. If the handshake state goes wrong, the command bits either stay 1 past the two or three RTC edges a command needs, or drop early. A faulty gate on pending or early writes shows up as a read-back holding the wrong bits in the bus cycle just after the write. The bench sweeps several small periods edge by edge, so each such fault shows up within a few RTC cycles.

// File: rtl/aonpt_pkg.sv
package aonpt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] A_AON = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD = 3'd3;
  localparam logic [ADDR_W-1:0] A_STS = 3'd4;
  localparam logic [ADDR_W-1:0] A_TMR = 3'd5;
  localparam int unsigned CMD_CLR_BIT = 0;
  localparam int unsigned CMD_RST_BIT = 1;
endpackage

// File: rtl/aonpt_sync.sv
module aonpt_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/aonpt_rtc_core.sv
module aonpt_rtc_core #(
  parameter int unsigned DW = 32
) (
  input  logic          rtc_clk,
  input  logic          rtc_rst_n,
  input  logic          cmd_tgl_b,
  input  logic          cmd_clr_b,
  input  logic          cmd_rst_b,
  input  logic          en_b,
  input  logic [DW-1:0] period_b,
  output logic [DW-1:0] aon_cnt,
  output logic [DW-1:0] tmr_cnt,
  output logic          flag,
  output logic          ack_tgl,
  output logic          pub_tgl
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  function automatic logic [DW-1:0] tmr_next(input logic [DW-1:0] c, input logic [DW-1:0] p);
    if (p == '0)     return c;
    else if (c <= ONE) return p;
    else             return c - ONE;
  endfunction

  function automatic logic tmr_fires(input logic [DW-1:0] c, input logic [DW-1:0] p);
    return (p != '0) && (c <= ONE);
  endfunction

  logic          tgl_s, en_s;
  logic [DW-1:0] per_q;

  aonpt_sync #(.W(1), .RST_VAL(1'b0)) u_tgl_sync (
    .clk(rtc_clk), .rst_n(rtc_rst_n), .d(cmd_tgl_b), .q(tgl_s));
  aonpt_sync #(.W(1), .RST_VAL(1'b1)) u_en_sync (
    .clk(rtc_clk), .rst_n(rtc_rst_n), .d(en_b), .q(en_s));

  // Named internal events
  logic act_w, do_rst_w, do_clr_w, fire_w;
  assign act_w    = tgl_s ^ ack_tgl;
  assign do_rst_w = act_w && cmd_rst_b;
  assign do_clr_w = act_w && cmd_clr_b;
  assign fire_w   = !do_rst_w && tmr_fires(tmr_cnt, per_q);

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      aon_cnt <= '0;
      tmr_cnt <= '0;
      per_q   <= '0;
      flag    <= 1'b0;
      ack_tgl <= 1'b0;
      pub_tgl <= 1'b0;
    end else begin
      pub_tgl <= ~pub_tgl;
      ack_tgl <= tgl_s;
      if (en_s) aon_cnt <= aon_cnt + ONE;
      if (do_rst_w) begin
        per_q   <= period_b;
        tmr_cnt <= period_b;
      end else begin
        tmr_cnt <= tmr_next(tmr_cnt, per_q);
      end
      flag <= fire_w | (flag & ~do_clr_w);
    end
  end

  p_aon_step_r2: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    en_s |=> (aon_cnt == $past(aon_cnt) + ONE));
  p_fire_sets_flag_r4: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    fire_w |=> flag);
  p_idle_no_flag_r5: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (per_q == '0 && !act_w) |=> $stable(flag));
  p_flag_sticky_r6: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (flag && !do_clr_w) |=> flag);
  p_cmd_gap_r8: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    act_w |=> !act_w);
endmodule

// File: rtl/aonpt_bus_regs.sv
module aonpt_bus_regs
  import aonpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              cmd_tgl,
  output logic              cmd_clr,
  output logic              cmd_rst,
  output logic              en,
  output logic [DW-1:0]     period,
  input  logic [DW-1:0]     aon_r,
  input  logic [DW-1:0]     tmr_r,
  input  logic              flag_r,
  input  logic              ack_r,
  input  logic              pub_r
);
  logic          pub_s, pub_last, primed;
  logic [DW-1:0] img_aon, img_tmr;
  logic          img_flag, img_ack;

  aonpt_sync #(.W(1), .RST_VAL(1'b0)) u_pub_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(pub_r), .q(pub_s));

  // Named internal events
  logic cap_w, busy_w, cmd_wr_w, cmd_take_w;
  assign cap_w      = pub_s ^ pub_last;
  assign busy_w     = cmd_tgl ^ img_ack;
  assign cmd_wr_w   = reg_wr && (reg_addr == A_CMD) &&
                      (reg_wdata[CMD_CLR_BIT] || reg_wdata[CMD_RST_BIT]);
  assign cmd_take_w = cmd_wr_w && primed && !busy_w;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      pub_last <= 1'b0;
      primed   <= 1'b0;
      img_aon  <= '0;
      img_tmr  <= '0;
      img_flag <= 1'b0;
      img_ack  <= 1'b0;
      cmd_tgl  <= 1'b0;
      cmd_clr  <= 1'b0;
      cmd_rst  <= 1'b0;
      en       <= 1'b1;
      period   <= '0;
    end else begin
      pub_last <= pub_s;
      if (cap_w) begin
        primed   <= 1'b1;
        img_aon  <= aon_r;
        img_tmr  <= tmr_r;
        img_flag <= flag_r;
        img_ack  <= ack_r;
      end
      if (reg_wr && reg_addr == A_CFG) en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_PER) period <= reg_wdata;
      if (cmd_take_w) begin
        cmd_clr <= reg_wdata[CMD_CLR_BIT];
        cmd_rst <= reg_wdata[CMD_RST_BIT];
        cmd_tgl <= ~cmd_tgl;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CFG: reg_rdata[0] = en;
      A_AON: reg_rdata = img_aon;
      A_PER: reg_rdata = period;
      A_CMD: begin
        reg_rdata[CMD_CLR_BIT] = busy_w & cmd_clr;
        reg_rdata[CMD_RST_BIT] = busy_w & cmd_rst;
      end
      A_STS: reg_rdata[0] = img_flag;
      A_TMR: reg_rdata = img_tmr;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = img_flag;

  p_cmd_hold_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    busy_w |=> ($stable(cmd_clr) && $stable(cmd_rst) && $stable(cmd_tgl)));
  p_no_cmd_unprimed_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !primed |=> $stable(cmd_tgl));
  p_irq_on_capture_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !$stable(irq) |-> $past(cap_w));
  p_busy_until_ack_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (busy_w && !cap_w) |=> busy_w);
endmodule

// File: rtl/aon_ptimer.sv
module aon_ptimer
  import aonpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              rtc_clk,
  input  logic              rtc_rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic          cmd_tgl, cmd_clr, cmd_rst, en;
  logic [DW-1:0] period, aon_cnt, tmr_cnt;
  logic          flag, ack_tgl, pub_tgl;

  aonpt_bus_regs #(.DW(DW)) u_bus (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .cmd_tgl(cmd_tgl), .cmd_clr(cmd_clr), .cmd_rst(cmd_rst),
    .en(en), .period(period),
    .aon_r(aon_cnt), .tmr_r(tmr_cnt), .flag_r(flag),
    .ack_r(ack_tgl), .pub_r(pub_tgl));

  aonpt_rtc_core #(.DW(DW)) u_rtc (
    .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .cmd_tgl_b(cmd_tgl), .cmd_clr_b(cmd_clr), .cmd_rst_b(cmd_rst),
    .en_b(en), .period_b(period),
    .aon_cnt(aon_cnt), .tmr_cnt(tmr_cnt), .flag(flag),
    .ack_tgl(ack_tgl), .pub_tgl(pub_tgl));
endmodule

// File: tb/aon_ptimer_tb.sv
module aon_ptimer_tb;
  localparam int DW = 32;
  logic          bus_clk = 1'b0, rtc_clk = 1'b0;
  logic          bus_rst_n = 1'b0, rtc_rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;
  int            n_tests = 0, n_fail = 0;
  bit            done = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #40  rtc_clk = ~rtc_clk;

  aon_ptimer #(.DW(DW)) u_dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge bus_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
    @(negedge bus_clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_rtc(input int n);
    repeat (n) @(negedge rtc_clk);
  endtask

  task automatic wait_idle(input string req);
    logic [DW-1:0] v;
    int guard = 0;
    rd(3'd3, v);
    while (v != 0 && guard < 200) begin
      rd(3'd3, v);
      guard++;
    end
    check(req, v, 0);
  endtask

  task automatic sweep(input logic [DW-1:0] p);
    logic [DW-1:0] v, m_cnt;
    logic m_flag;
    wr(3'd2, p);
    wr(3'd3, 3);
    rd(3'd3, v); check("R7 busy readback", v, 3);
    wait_idle("R7 self-clear");
    wait_rtc(1);
    m_cnt = p; m_flag = 1'b0;
    rd(3'd5, v); check("R3 reload on reset cmd", v, m_cnt);
    rd(3'd4, v); check("R6 clear removes flag", v, 0);
    for (int k = 0; k < 2 * int'(p) + 4; k++) begin
      wait_rtc(1);
      if (p != 0) begin
        if (m_cnt <= 1) begin m_cnt = p; m_flag = 1'b1; end
        else m_cnt = m_cnt - 1;
      end
      rd(3'd5, v);
      check(p == 0 ? "R5 idle count" : "R4 timer step", v, m_cnt);
      rd(3'd4, v);
      check(p == 0 ? "R5 no flag" : "R4/R6 flag", v, {31'b0, m_flag});
      check("R10 irq level", {31'b0, irq}, {31'b0, m_flag});
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, base;
    repeat (3) @(posedge rtc_clk);
    #1;
    bus_rst_n = 1'b1; rtc_rst_n = 1'b1;
    // R1: reset state before the first RTC edge
    rd(3'd0, v); check("R1 cfg", v, 1);
    rd(3'd1, v); check("R1 aon", v, 0);
    rd(3'd2, v); check("R1 period", v, 0);
    rd(3'd3, v); check("R1 cmd", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd5, v); check("R1 timer", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R9: reset command before first RTC edge is dropped
    wr(3'd2, 7);
    wr(3'd3, 2);
    rd(3'd3, v); check("R9 early cmd readback", v, 0);
    wait_rtc(4);
    rd(3'd5, v); check("R9 early cmd no effect", v, 0);
    rd(3'd3, v); check("R9 still idle", v, 0);

    // R2: always-on counter steps
    rd(3'd1, base);
    for (int n = 1; n <= 6; n++) begin
      wait_rtc(1);
      rd(3'd1, v); check("R2 aon step", v, base + n);
    end
    wr(3'd0, 0);
    rd(3'd0, v); check("R2 cfg off", v, 0);
    wait_rtc(4);
    rd(3'd1, base);
    wait_rtc(5);
    rd(3'd1, v); check("R2 frozen", v, base);
    wr(3'd0, 1);
    wait_rtc(4);
    rd(3'd1, base);
    wait_rtc(3);
    rd(3'd1, v); check("R2 resumed", v, base + 3);

    // R3/R4/R5: timer sweeps over small periods
    sweep(0);
    sweep(1);
    sweep(2);
    sweep(3);
    sweep(5);

    // R6: reset alone keeps flag; R8: write while pending dropped
    wr(3'd2, 20);
    wr(3'd3, 2);
    wait_idle("R7 reset done");
    rd(3'd4, v); check("R6 reset keeps flag", v, 1);
    check("R10 irq held", {31'b0, irq}, 1);
    wait_rtc(1);
    rd(3'd5, v); check("R3 reload 20", v, 20);
    wr(3'd3, 1);
    rd(3'd3, v); check("R7 clear pending", v, 1);
    wr(3'd3, 2);
    rd(3'd3, v); check("R8 pending write dropped", v, 1);
    wait_idle("R7 clear done");
    wait_rtc(1);
    rd(3'd4, v); check("R6 cleared", v, 0);
    check("R10 irq low", {31'b0, irq}, 0);
    rd(3'd3, v); check("R8 no late command", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule